// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a bus-attached SPI master with a small word-addressed register bank. Software configures it through two general control words and moves bytes through one data register. Any access to the data register, whether a load or a fetch, performs a full-duplex byte exchange on the serial pins. A load sends the value just written. A fetch sends whatever the data register already holds and returns the byte that came back from the slave. The received byte always replaces the data register contents.

The serial side runs SPI mode 0. SCK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and the most significant bit goes first. One active-low chip select frames each byte. The bank also holds a CRC polynomial word, two CRC result words and two audio-port configuration words. These are placeholders: they always read their fixed reset values and ignore writes.

The bus side uses a valid/ready handshake. Every access except one to the data register completes in the cycle it is presented. A data-register access is stalled until its byte has finished shifting.

Top module: `spi_regbank_master`

## Requirements
- R1: After a synchronous active-low reset the registers read as follows: both control words 0x0, status 0x0A, CRC polynomial 0x07, both CRC result words 0x0, audio configuration 0x0 and audio prescaler 0x02. The data register holds 0x0C, so the first data fetch sends 0x0C.
- R2: A write to the data register (offset 0x0C) loads bits [7:0] of the write data and shifts them out. When the byte completes, the byte received on MISO replaces the data register and status bit 0 (receive-full) is set, so the status reads 0x0B.
- R3: A read of the data register first exchanges the current data register contents. It then returns the received byte (zero-extended), stores that byte as the new contents and clears status bit 0.
- R4: The status register (offset 0x08) cannot be written. Its bits are: bit 7 busy while shifting, bit 3 constant 1, bit 1 transmit-empty (1 when idle) and bit 0 receive-full. All other bits read 0.
- R5: Writes to the CRC polynomial (0x10), receive CRC (0x14), transmit CRC (0x18), audio configuration (0x1C) and audio prescaler (0x20) words are ignored. Reads of these words return their reset values.
- R6: Control word 1 (offset 0x00) and control word 2 (offset 0x04) are 32-bit read/write registers that return the last value written.
- R7: The window decodes a 10-bit byte address; bits [1:0] are ignored. A read of any other offset returns 0, and a write to one changes no register.
- R8: One exchange holds chip select low for exactly 32 clock cycles. In that time SCK gives 8 rising edges, each high phase lasting 2 clocks, and MOSI carries the sent byte MSB first.
- R9: Accesses to registers other than the data register complete with ready high in the cycle they are presented. A data-register access keeps ready low until the byte has finished shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets the fetch-triggered exchange: a data-register read must send the old contents and return the newly received byte. A design that returned the stale value, or sent nothing, fails both the returned-value check and the MOSI capture. It also targets the receive-full flag, which only a fetch may clear. A design that cleared it on a write, or never set it, reads 0x0A where 0x0B is due. Writes to the status word, the placeholder words and an unmapped offset are each followed by reads, so any write that leaked into a register shows up. The chip-select, SCK high-phase and rising-edge counts, together with the stall length, catch a wrong divider, an extra or missing bit, and a bus that completes before the byte is done.

// File: rtl/spim_pkg.sv
// Shared definitions for the register-mapped SPI master.
// Assumes a 32-bit register bank with word-aligned offsets.
package spim_pkg;

    localparam int unsigned OFS_CTRL1 = 32'h00;
    localparam int unsigned OFS_CTRL2 = 32'h04;
    localparam int unsigned OFS_STAT  = 32'h08;
    localparam int unsigned OFS_DATA  = 32'h0C;
    localparam int unsigned OFS_POLY  = 32'h10;
    localparam int unsigned OFS_RCRC  = 32'h14;
    localparam int unsigned OFS_TCRC  = 32'h18;
    localparam int unsigned OFS_ACFG  = 32'h1C;
    localparam int unsigned OFS_APRE  = 32'h20;

    localparam logic [31:0] RST_DATA = 32'h0000_000C;
    localparam logic [31:0] RST_POLY = 32'h0000_0007;
    localparam logic [31:0] RST_APRE = 32'h0000_0002;

    typedef enum logic [3:0] {
        REG_CTRL1, REG_CTRL2, REG_STAT, REG_DATA, REG_POLY,
        REG_RCRC, REG_TCRC, REG_ACFG, REG_APRE, REG_NONE
    } reg_id_e;

    typedef enum logic [1:0] {
        XS_IDLE, XS_SHIFT, XS_DONE
    } xfer_st_e;

endpackage

// File: rtl/spim_addr_decode.sv
// Address decoder: maps a byte address to a register identifier.
// Assumes word-aligned registers; address bits [1:0] are ignored.
module spim_addr_decode
    import spim_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           rid
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;

    assign word_idx = addr[ADDR_W-1:2];

    // Compare the word index with each register slot.
    always_comb begin
        if      (word_idx == WORD_W'(OFS_CTRL1 >> 2)) rid = REG_CTRL1;
        else if (word_idx == WORD_W'(OFS_CTRL2 >> 2)) rid = REG_CTRL2;
        else if (word_idx == WORD_W'(OFS_STAT  >> 2)) rid = REG_STAT;
        else if (word_idx == WORD_W'(OFS_DATA  >> 2)) rid = REG_DATA;
        else if (word_idx == WORD_W'(OFS_POLY  >> 2)) rid = REG_POLY;
        else if (word_idx == WORD_W'(OFS_RCRC  >> 2)) rid = REG_RCRC;
        else if (word_idx == WORD_W'(OFS_TCRC  >> 2)) rid = REG_TCRC;
        else if (word_idx == WORD_W'(OFS_ACFG  >> 2)) rid = REG_ACFG;
        else if (word_idx == WORD_W'(OFS_APRE  >> 2)) rid = REG_APRE;
        else                                          rid = REG_NONE;
    end

endmodule

// File: rtl/spim_shift_engine.sv
// Mode-0 byte shifter: SCK idles low, MISO sampled on rising SCK,
// MOSI advanced on falling SCK, MSB first.
// Assumes start is only raised while the engine is not running.
// One SCK half period lasts DIV_HALF clocks.
module spim_shift_engine #(
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);

    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic              run_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;

    // Divider, bit counter, shift registers and frame control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q   <= 1'b1;
                    cs_n    <= 1'b0;
                    sck     <= 1'b0;
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    tx_sh_q <= tx_byte;
                end
            end else if (cnt_q == CNT_W'(DIV_HALF - 1)) begin
                cnt_q <= '0;
                sck   <= ~sck;
                if (!sck) begin
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
                end else if (bit_q == BIT_W'(DATA_W - 1)) begin
                    run_q <= 1'b0;
                    cs_n  <= 1'b1;
                    done  <= 1'b1;
                end else begin
                    bit_q   <= bit_q + 1'b1;
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mosi    = tx_sh_q[DATA_W-1];
    assign rx_byte = rx_sh_q;
    assign busy    = run_q;

    // R8: SCK stays low whenever chip select is released.
    p_sck_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R8: MOSI holds steady while SCK is high inside a frame.
    p_mosi_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck) |-> $stable(mosi));

    // R8: completion pulse coincides with chip select release.
    p_done_releases_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));

endmodule

// File: rtl/spi_regbank_master.sv
// Register-mapped SPI master top. Decodes a small register window,
// holds the control and data registers, and runs one mode-0 byte
// exchange per data-register access (read or write).
// Assumes the bus master holds valid, write, addr and wdata stable
// until it sees ready.
module spi_regbank_master
    import spim_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int BUS_W    = 32,
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    input  logic              spi_miso
);

    reg_id_e           rid;
    xfer_st_e          st_q;
    logic [BUS_W-1:0]  ctrl1_q;
    logic [BUS_W-1:0]  ctrl2_q;
    logic [DATA_W-1:0] dr_q;
    logic              rxne_q;
    logic              accept;
    logic              start;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;
    logic              eng_busy;
    logic              eng_done;
    logic [BUS_W-1:0]  status_w;

    spim_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .rid  (rid)
    );

    spim_shift_engine #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_byte),
        .rx_byte (rx_byte),
        .busy    (eng_busy),
        .done    (eng_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .miso    (spi_miso)
    );

    // Handshake: stall data-register accesses until the byte is back.
    always_comb begin
        start     = (st_q == XS_IDLE) && bus_valid && (rid == REG_DATA);
        tx_byte   = bus_write ? bus_wdata[DATA_W-1:0] : dr_q;
        bus_ready = ((st_q == XS_IDLE) && !start) || (st_q == XS_DONE);
        accept    = bus_valid && bus_ready;
    end

    // Exchange sequencer: idle, shifting, then one completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= XS_IDLE;
        end else begin
            case (st_q)
                XS_IDLE:  if (start)    st_q <= XS_SHIFT;
                XS_SHIFT: if (eng_done) st_q <= XS_DONE;
                XS_DONE:  if (accept)   st_q <= XS_IDLE;
                default:                st_q <= XS_IDLE;
            endcase
        end
    end

    // Control registers: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1_q <= '0;
            ctrl2_q <= '0;
        end else if (accept && bus_write && (st_q == XS_IDLE)) begin
            if (rid == REG_CTRL1) ctrl1_q <= bus_wdata;
            if (rid == REG_CTRL2) ctrl2_q <= bus_wdata;
        end
    end

    // Data register and receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q   <= DATA_W'(RST_DATA);
            rxne_q <= 1'b0;
        end else begin
            if (start && bus_write) dr_q <= bus_wdata[DATA_W-1:0];
            if (eng_done) begin
                dr_q   <= rx_byte;
                rxne_q <= 1'b1;
            end else if ((st_q == XS_DONE) && accept && !bus_write) begin
                rxne_q <= 1'b0;
            end
        end
    end

    // Status word assembly: busy, fixed bit, transmit-empty, receive-full.
    always_comb begin
        status_w    = '0;
        status_w[7] = eng_busy;
        status_w[3] = 1'b1;
        status_w[1] = ~eng_busy;
        status_w[0] = rxne_q;
    end

    // Read multiplexer over the register window.
    always_comb begin
        case (rid)
            REG_CTRL1: bus_rdata = ctrl1_q;
            REG_CTRL2: bus_rdata = ctrl2_q;
            REG_STAT:  bus_rdata = status_w;
            REG_DATA:  bus_rdata = BUS_W'(dr_q);
            REG_POLY:  bus_rdata = BUS_W'(RST_POLY);
            REG_APRE:  bus_rdata = BUS_W'(RST_APRE);
            default:   bus_rdata = '0;
        endcase
    end

    // R2: data register holds while the byte is still shifting.
    p_dr_hold_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == XS_SHIFT) && !eng_done) |=> $stable(dr_q));

    // R2: completion sets receive-full and releases the bus.
    p_rxne_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (rxne_q && bus_ready));

    // R6: control word 1 only changes on an accepted write to it.
    p_ctrl1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && bus_write && (rid == REG_CTRL1)) |=> $stable(ctrl1_q));

    // R9: chip select is active for the whole shift phase.
    p_cs_during_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == XS_SHIFT) && !eng_done) |-> !spi_cs_n);

endmodule

// File: tb/spi_regbank_master_test.sv
module spi_regbank_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_regbank_master uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    // Slave model: preload on chip select, shift on falling SCK,
    // capture MOSI on rising SCK.
    logic [7:0] slv_byte = '0;
    logic [7:0] slv_sh = '0;
    logic [7:0] cap = '0;
    int rise_cnt = 0;
    int hi_cnt = 0;
    int low_cnt = 0;

    assign spi_miso = slv_sh[7];

    always @(negedge spi_cs_n) slv_sh = slv_byte;
    always @(negedge spi_sck) if (!spi_cs_n) slv_sh = {slv_sh[6:0], 1'b0};
    always @(posedge spi_sck) begin
        cap = {cap[6:0], spi_mosi};
        rise_cnt++;
    end
    always @(posedge clk) begin
        if (!spi_cs_n) low_cnt++;
        if (!spi_cs_n && spi_sck) hi_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [9:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
        waits = 0;
        forever begin
            #1;
            if (bus_ready) break;
            @(negedge clk);
            waits++;
        end
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [9:0]  a;
        logic [31:0] wd;
        logic [7:0]  slv;
        logic [31:0] exp;
        logic        cm;
        logic [7:0]  em;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 10'h000, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h008, 32'h0, 8'h00, 32'h0000_000A, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h010, 32'h0, 8'h00, 32'h0000_0007, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h014, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h018, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h01C, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h020, 32'h0, 8'h00, 32'h0000_0002, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h004, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 10'h00C, 32'h0, 8'h5A, 32'h0000_005A, 1'b1, 8'h0C, 4'd3},  // R3 sends reset 0x0C
        '{1'b0, 10'h008, 32'h0, 8'h00, 32'h0000_000A, 1'b0, 8'h00, 4'd3},  // R3 flag cleared
        '{1'b1, 10'h000, 32'hDEAD_BEEF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd6},  // R6
        '{1'b0, 10'h000, 32'h0, 8'h00, 32'hDEAD_BEEF, 1'b0, 8'h00, 4'd6},  // R6
        '{1'b1, 10'h004, 32'h1234_5678, 8'h00, 32'h0, 1'b0, 8'h00, 4'd6},  // R6
        '{1'b0, 10'h004, 32'h0, 8'h00, 32'h1234_5678, 1'b0, 8'h00, 4'd6},  // R6
        '{1'b1, 10'h00C, 32'h0000_01A5, 8'h3C, 32'h0, 1'b1, 8'hA5, 4'd2},  // R2
        '{1'b0, 10'h008, 32'h0, 8'h00, 32'h0000_000B, 1'b0, 8'h00, 4'd2},  // R2 flag set
        '{1'b1, 10'h008, 32'hFFFF_FFFF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd4},  // R4
        '{1'b0, 10'h008, 32'h0, 8'h00, 32'h0000_000B, 1'b0, 8'h00, 4'd4},  // R4
        '{1'b1, 10'h010, 32'h0000_00FF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b0, 10'h010, 32'h0, 8'h00, 32'h0000_0007, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 10'h014, 32'h0000_00FF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b0, 10'h014, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 10'h020, 32'h0000_0000, 8'h00, 32'h0, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b0, 10'h020, 32'h0, 8'h00, 32'h0000_0002, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 10'h01C, 32'h0000_FFFF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b0, 10'h01C, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 10'h3FC, 32'hFFFF_FFFF, 8'h00, 32'h0, 1'b0, 8'h00, 4'd7},  // R7
        '{1'b0, 10'h3FC, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd7},  // R7
        '{1'b0, 10'h024, 32'h0, 8'h00, 32'h0000_0000, 1'b0, 8'h00, 4'd7},  // R7
        '{1'b0, 10'h00C, 32'h0, 8'h81, 32'h0000_0081, 1'b1, 8'h3C, 4'd3},  // R3 sends last rx
        '{1'b0, 10'h008, 32'h0, 8'h00, 32'h0000_000A, 1'b0, 8'h00, 4'd3},  // R3
        '{1'b0, 10'h000, 32'h0, 8'h00, 32'hDEAD_BEEF, 1'b0, 8'h00, 4'd7}   // R7 no alias
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w;
        string tag;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R8 idle pins", {30'b0, spi_cs_n, spi_sck}, 32'h2);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            slv_byte = v.slv;
            acc(v.wr, v.a, v.wd, rd, w);
            if (!v.wr) chk(rd === v.exp, tag, rd, v.exp);
            if (v.cm) chk(cap === v.em, {tag, " mosi"}, {24'b0, cap}, {24'b0, v.em});
        end

        // R8 and R9: frame timing and stall length on a data write.
        rise_cnt = 0; hi_cnt = 0; low_cnt = 0;
        slv_byte = 8'h69;
        acc(1'b1, 10'h00C, 32'h96, rd, w);
        repeat (2) @(posedge clk);
        chk(rise_cnt == 8, "R8 rising edges", rise_cnt, 8);
        chk(hi_cnt == 16, "R8 sck high clocks", hi_cnt, 16);
        chk(low_cnt == 32, "R8 cs low clocks", low_cnt, 32);
        chk(cap === 8'h96, "R8 mosi msb first", {24'b0, cap}, 32'h96);
        chk(w >= 32, "R9 data access stalled", w, 32);
        acc(1'b0, 10'h00C, 32'h0, rd, w);
        chk(rd === 32'h69, "R2 received byte stored", rd, 32'h69);
        chk(cap === 8'h69, "R3 fetch resends stored", {24'b0, cap}, 32'h69);
        acc(1'b0, 10'h004, 32'h0, rd, w);
        chk(w == 0, "R9 register access no stall", w, 0);

        // R1: reset after traffic restores every value.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        acc(1'b0, 10'h000, 32'h0, rd, w);
        chk(rd === 32'h0, "R1 ctrl1 after reset", rd, 32'h0);
        acc(1'b0, 10'h004, 32'h0, rd, w);
        chk(rd === 32'h0, "R1 ctrl2 after reset", rd, 32'h0);
        acc(1'b0, 10'h008, 32'h0, rd, w);
        chk(rd === 32'h0A, "R1 status after reset", rd, 32'h0A);
        slv_byte = 8'hC3;
        acc(1'b0, 10'h00E, 32'h0, rd, w);
        chk(cap === 8'h0C, "R1 data reset value sent", {24'b0, cap}, 32'h0C);
        chk(rd === 32'hC3, "R7 low address bits ignored", rd, 32'hC3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule